// File: doc/BRIEF.md
# Processor Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents a vector of interrupts that are both pending and enabled, along with an 8-bit priority for each. The block picks the best candidate and checks it against a programmable priority threshold. It then checks whether the candidate may preempt the interrupt currently being serviced. If both checks pass and signalling is enabled, it raises a request line to the processor.

Software works through a small register port. Reading the acknowledge register takes the chosen interrupt. Its ID is returned and its group priority becomes the new running priority. The block also emits a one-cycle pulse telling the distributor to move that interrupt from pending to active. Writing an ID to the completion register retires the most recent active interrupt and restores the previous running priority. A matching pulse tells the distributor to clear the active state. Nested servicing is tracked with a small stack of active priorities. A fixed spurious code, 0x3FF, is returned whenever nothing can be taken.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, the control register (0x00) reads 0, the threshold register (0x04) reads 0, the split register (0x08) reads 2, the running-priority register (0x14) reads 0xFF, the acknowledge (0x0C) and peek (0x18) registers read 0x3FF, and irqOut is low.
- R2: Among candidates, the numerically lowest priority wins, and equal priorities go to the lowest ID. A read of 0x18 returns the winner's ID (0x3FF if there is no candidate), ignoring the threshold and preemption, and changes no state.
- R3: A candidate qualifies only if its priority is strictly lower than the threshold register value (bits 7:0 of 0x04).
- R4: The split register holds 3 bits (bits 2:0 of 0x08). Writes below 2 store 2. The group priority is the priority with bits [split:0] cleared.
- R5: A candidate qualifies only if its group priority is strictly lower than the running priority.
- R6: irqOut is high exactly when bit 0 of the control register is 1 and a candidate qualifies.
- R7: Reading 0x0C while a candidate qualifies returns its ID, whatever the control bit. The candidate's group priority is pushed as the running priority, and ackValid/ackId pulse in the following cycle. With no qualifier the read returns 0x3FF and has no effect.
- R8: Writing 0x10 with the ID of the most recently acknowledged interrupt pops it, restores the previous running priority (0xFF when none is left), and pulses eoiValid/eoiId in the following cycle. Writing any other ID, or writing with nothing active, is ignored.
- R9: While STACK_DEPTH interrupts are active, nothing qualifies: irqOut stays low and 0x0C reads 0x3FF.
- R10: Register 0x14 reads the group priority of the most recently acknowledged, still-active interrupt, or 0xFF when none is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candVec | input | NUM_IRQ | Pending-and-enabled interrupts from the distributor |
| prioFlat | input | NUM_IRQ*PRIO_W | Priority of each interrupt, ID i in slice i |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (side effect on 0x0C) |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| irqOut | output | 1 | Interrupt request to the processor |
| ackValid | output | 1 | Pulse: move ackId from pending to active |
| ackId | output | ID_W | Interrupt ID taken |
| eoiValid | output | 1 | Pulse: clear active state of eoiId |
| eoiId | output | ID_W | Interrupt ID completed |

## Verification
The bench builds the block with NUM_IRQ=8 and STACK_DEPTH=2. The shallow stack means the full-stack refusal and its release on completion can be reached after only two nested acknowledges. The bench acts as the distributor: it withdraws an interrupt from candVec once it has been acknowledged. It then walks ties, threshold edges, two split settings, and in-order and mismatched completions against expected values derived from the priorities.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_MASK = 8'h04;
  localparam logic [7:0] OFF_SPLIT = 8'h08;
  localparam logic [7:0] OFF_ACK = 8'h0C;
  localparam logic [7:0] OFF_EOI = 8'h10;
  localparam logic [7:0] OFF_RUN = 8'h14;
  localparam logic [7:0] OFF_PEEK = 8'h18;
  localparam int SPLIT_W = 3;
  localparam int SPLIT_MIN = 2;
  localparam int SPURIOUS = 1023;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrSplit;
    logic doAck;
    logic doEoi;
  } strobe_t;
endpackage

// File: rtl/cpuif_arbiter.sv
module cpuif_arbiter #(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W = 8,
  parameter int ID_W = 10
) (
  input  logic [NUM_IRQ-1:0]        candVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  output logic                      bestValid,
  output logic [ID_W-1:0]           bestId,
  output logic [PRIO_W-1:0]         bestPrio
);
  always_comb begin
    bestValid = 1'b0;
    bestId = '0;
    bestPrio = '1;
    // strict compare keeps the earlier (lower) ID on a tie
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (candVec[i] && (!bestValid || prioFlat[i*PRIO_W +: PRIO_W] < bestPrio)) begin
        bestValid = 1'b1;
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
        bestId = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl
  import cpuif_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic            regWe,
  input  logic            regRe,
  input  logic [7:0]      regAddr,
  input  logic [ID_W-1:0] wrId,
  input  logic            qualify,
  input  logic            stackEmpty,
  input  logic [ID_W-1:0] topId,
  output strobe_t         strb
);
  logic ackHit;

  assign ackHit = regRe && (regAddr == OFF_ACK) && qualify;

  always_comb begin
    strb.wrCtrl = regWe && (regAddr == OFF_CTRL);
    strb.wrMask = regWe && (regAddr == OFF_MASK);
    strb.wrSplit = regWe && (regAddr == OFF_SPLIT);
    strb.doAck = ackHit;
    strb.doEoi = regWe && (regAddr == OFF_EOI) && !stackEmpty &&
                 (wrId == topId) && !ackHit;
  end
endmodule

// File: rtl/cpuif_datapath.sv
module cpuif_datapath
  import cpuif_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int ID_W = 10,
  parameter int STACK_DEPTH = 4,
  localparam int PTR_W = $clog2(STACK_DEPTH + 1),
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic               bestValid,
  input  logic [ID_W-1:0]    bestId,
  input  logic [PRIO_W-1:0]  bestPrio,
  output logic [31:0]        regRdata,
  output logic               irqOut,
  output logic               qualify,
  output logic               stackEmpty,
  output logic [ID_W-1:0]    topId,
  output logic               ackValid,
  output logic [ID_W-1:0]    ackId,
  output logic               eoiValid,
  output logic [ID_W-1:0]    eoiId,
  output logic               ctrlEn,
  output logic [SPLIT_W-1:0] splitReg,
  output logic [PRIO_W-1:0]  runPrio,
  output logic [PTR_W-1:0]   depth
);
  logic [PRIO_W-1:0] maskReg;
  logic [PRIO_W-1:0] stkPrio [STACK_DEPTH];
  logic [ID_W-1:0]   stkId [STACK_DEPTH];
  logic [PRIO_W-1:0] groupMask;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  pushIdx;
  logic              stackFull;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata;

  always_comb begin
    for (int k = 0; k < PRIO_W; k++) groupMask[k] = (k > int'(splitReg));
  end

  assign stackEmpty = (depth == '0);
  assign stackFull = (depth == PTR_W'(STACK_DEPTH));
  assign topIdx = IDX_W'(depth - 1'b1);
  assign pushIdx = IDX_W'(depth);
  assign runPrio = stackEmpty ? '1 : stkPrio[topIdx];
  assign topId = stackEmpty ? '0 : stkId[topIdx];

  assign qualify = bestValid && (bestPrio < maskReg) &&
                   ((bestPrio & groupMask) < runPrio) && !stackFull;
  assign irqOut = ctrlEn && qualify;

  always_comb begin
    case (regAddr)
      OFF_CTRL:  regRdata = {31'b0, ctrlEn};
      OFF_MASK:  regRdata = 32'(maskReg);
      OFF_SPLIT: regRdata = 32'(splitReg);
      OFF_ACK:   regRdata = qualify ? 32'(bestId) : 32'(SPURIOUS);
      OFF_RUN:   regRdata = 32'(runPrio);
      OFF_PEEK:  regRdata = bestValid ? 32'(bestId) : 32'(SPURIOUS);
      default:   regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn <= 1'b0;
      maskReg <= '0;
      splitReg <= SPLIT_W'(SPLIT_MIN);
      depth <= '0;
      ackValid <= 1'b0;
      ackId <= '0;
      eoiValid <= 1'b0;
      eoiId <= '0;
      for (int s = 0; s < STACK_DEPTH; s++) begin
        stkPrio[s] <= '1;
        stkId[s] <= '0;
      end
    end else begin
      ackValid <= strb.doAck;
      eoiValid <= strb.doEoi;
      if (strb.wrCtrl) ctrlEn <= regWdata[0];
      if (strb.wrMask) maskReg <= regWdata[PRIO_W-1:0];
      if (strb.wrSplit)
        splitReg <= (regWdata[SPLIT_W-1:0] < SPLIT_W'(SPLIT_MIN)) ?
                    SPLIT_W'(SPLIT_MIN) : regWdata[SPLIT_W-1:0];
      if (strb.doAck) begin
        ackId <= bestId;
        stkPrio[pushIdx] <= bestPrio & groupMask;
        stkId[pushIdx] <= bestId;
        depth <= depth + 1'b1;
      end else if (strb.doEoi) begin
        eoiId <= topId;
        depth <= depth - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W = 8,
  parameter int ID_W = 10,
  parameter int STACK_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        candVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic                      regWe,
  input  logic                      regRe,
  input  logic [7:0]                regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  output logic                      irqOut,
  output logic                      ackValid,
  output logic [ID_W-1:0]           ackId,
  output logic                      eoiValid,
  output logic [ID_W-1:0]           eoiId
);
  localparam int PTR_W = $clog2(STACK_DEPTH + 1);

  strobe_t             strb;
  logic                bestValid;
  logic [ID_W-1:0]     bestId;
  logic [PRIO_W-1:0]   bestPrio;
  logic                qualify;
  logic                stackEmpty;
  logic [ID_W-1:0]     topId;
  logic                ctrlEn;
  logic [SPLIT_W-1:0]  splitReg;
  logic [PRIO_W-1:0]   runPrio;
  logic [PTR_W-1:0]    depth;
  logic                doAck;
  logic                doEoi;

  assign doAck = strb.doAck;
  assign doEoi = strb.doEoi;

  cpuif_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .candVec(candVec), .prioFlat(prioFlat),
    .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio)
  );

  cpuif_ctrl #(.ID_W(ID_W)) u_ctrl (
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .wrId(regWdata[ID_W-1:0]), .qualify(qualify),
    .stackEmpty(stackEmpty), .topId(topId), .strb(strb)
  );

  cpuif_datapath #(.PRIO_W(PRIO_W), .ID_W(ID_W), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regWdata(regWdata),
    .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio),
    .regRdata(regRdata), .irqOut(irqOut), .qualify(qualify),
    .stackEmpty(stackEmpty), .topId(topId),
    .ackValid(ackValid), .ackId(ackId), .eoiValid(eoiValid), .eoiId(eoiId),
    .ctrlEn(ctrlEn), .splitReg(splitReg), .runPrio(runPrio), .depth(depth)
  );
endmodule

// File: rtl/cpuif_checker.sv
module cpuif_checker #(
  parameter int PRIO_W = 8,
  parameter int ID_W = 10,
  parameter int STACK_DEPTH = 4,
  localparam int PTR_W = $clog2(STACK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqOut,
  input logic              ctrlEn,
  input logic              doAck,
  input logic              doEoi,
  input logic [PRIO_W-1:0] runPrio,
  input logic [2:0]        splitReg,
  input logic [PTR_W-1:0]  depth,
  input logic              ackValid,
  input logic [ID_W-1:0]   ackId
);
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ctrlEn);

  a_r7_ack_lowers_running: assert property (@(posedge clk) disable iff (!rstN)
    doAck |=> runPrio < $past(runPrio));

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doAck |=> ackValid && (ackId != ID_W'(1023)));

  a_r8_eoi_raises_running: assert property (@(posedge clk) disable iff (!rstN)
    doEoi |=> runPrio > $past(runPrio));

  a_r4_split_floor: assert property (@(posedge clk) disable iff (!rstN)
    splitReg >= 3'd2);

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(depth) <= STACK_DEPTH);
endmodule

bind cpu_irq_iface cpuif_checker #(.PRIO_W(PRIO_W), .ID_W(ID_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .ctrlEn(ctrlEn), .doAck(doAck),
  .doEoi(doEoi), .runPrio(runPrio), .splitReg(splitReg), .depth(depth),
  .ackValid(ackValid), .ackId(ackId)
);

// File: tb/tb_cpu_irq_iface.sv
module tb_cpu_irq_iface;
  localparam int N = 8;
  localparam int PW = 8;
  localparam int IW = 10;
  localparam int SD = 2;
  localparam int SPUR = 1023;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] candVec = '0;
  logic [N*PW-1:0] prioFlat;
  logic [PW-1:0] prioArr [N];
  logic regWe = 1'b0, regRe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irqOut, ackValid, eoiValid;
  logic [IW-1:0] ackId, eoiId;
  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) prioFlat[i*PW +: PW] = prioArr[i];

  cpu_irq_iface #(.NUM_IRQ(N), .PRIO_W(PW), .ID_W(IW), .STACK_DEPTH(SD)) dut (
    .clk(clk), .rstN(rstN), .candVec(candVec), .prioFlat(prioFlat),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .ackValid(ackValid), .ackId(ackId),
    .eoiValid(eoiValid), .eoiId(eoiId)
  );

  task automatic check(string req, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regRead(input logic [7:0] a, output int data);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1 data = int'(regRdata);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  // acknowledge read that also checks the distributor pulse one cycle on
  task automatic ackExpect(string req, int expId);
    int d;
    regRead(8'h0C, d);
    check(req, d, expId);
    check(req, int'(ackValid), (expId != SPUR) ? 1 : 0);
    if (expId != SPUR) check(req, int'(ackId), expId);
  endtask

  task automatic regWrite(input logic [7:0] a, input int data);
    @(negedge clk);
    regAddr = a; regWdata = 32'(data); regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic eoiExpect(string req, int id, bit taken);
    regWrite(8'h10, id);
    check(req, int'(eoiValid), int'(taken));
    if (taken) check(req, int'(eoiId), id);
  endtask

  task automatic readExpect(string req, logic [7:0] a, int exp);
    int d;
    regRead(a, d);
    check(req, d, exp);
  endtask

  task automatic irqExpect(string req, bit exp);
    @(negedge clk);
    #1 check(req, int'(irqOut), int'(exp));
  endtask

  task automatic setCand(int id, int p);
    prioArr[id] = PW'(p);
    candVec[id] = 1'b1;
  endtask

  task automatic t_reset();
    readExpect("R1 ctrl", 8'h00, 0);
    readExpect("R1 mask", 8'h04, 0);
    readExpect("R1 split", 8'h08, 2);
    readExpect("R1 R10 running", 8'h14, 8'hFF);
    readExpect("R1 ack", 8'h0C, SPUR);
    readExpect("R1 peek", 8'h18, SPUR);
    irqExpect("R1 irq", 1'b0);
  endtask

  task automatic t_arbitrate();
    setCand(5, 8'h40); setCand(3, 8'h40); setCand(6, 8'h80);
    readExpect("R2 tie lowest id", 8'h18, 3);
    readExpect("R2 peek no side effect", 8'h18, 3);
    candVec = '0; setCand(6, 8'h80);
    readExpect("R2 single", 8'h18, 6);
    candVec = '0; setCand(0, 8'h90); setCand(7, 8'h10);
    readExpect("R2 lowest value", 8'h18, 7);
    candVec = '0;
  endtask

  task automatic t_split();
    regWrite(8'h08, 0);
    readExpect("R4 clamp 0", 8'h08, 2);
    regWrite(8'h08, 1);
    readExpect("R4 clamp 1", 8'h08, 2);
    regWrite(8'h08, 5);
    readExpect("R4 store 5", 8'h08, 5);
    regWrite(8'h08, 2);
  endtask

  task automatic t_mask();
    regWrite(8'h00, 1);
    regWrite(8'h04, 8'h40);
    setCand(3, 8'h40);
    irqExpect("R3 equal blocked", 1'b0);
    ackExpect("R3 equal ack", SPUR);
    regWrite(8'h04, 8'h41);
    irqExpect("R3 R6 below passes", 1'b1);
    candVec = '0;
    irqExpect("R6 no cand", 1'b0);
    regWrite(8'h04, 8'hF0);
  endtask

  task automatic t_nest();
    setCand(3, 8'h43);
    ackExpect("R7 ack first", 3);
    candVec[3] = 1'b0;
    readExpect("R10 group running", 8'h14, 8'h40);
    setCand(2, 8'h44);
    irqExpect("R5 same group blocked", 1'b0);
    ackExpect("R5 same group ack", SPUR);
    readExpect("R2 peek ignores preempt", 8'h18, 2);
    prioArr[2] = 8'h38;
    irqExpect("R5 preempts", 1'b1);
    ackExpect("R7 ack nested", 2);
    candVec[2] = 1'b0;
    readExpect("R10 nested running", 8'h14, 8'h38);
    eoiExpect("R8 mismatch ignored", 3, 1'b0);
    readExpect("R8 mismatch running", 8'h14, 8'h38);
    eoiExpect("R8 pop nested", 2, 1'b1);
    readExpect("R8 restore", 8'h14, 8'h40);
    eoiExpect("R8 pop first", 3, 1'b1);
    readExpect("R8 idle", 8'h14, 8'hFF);
    eoiExpect("R8 empty ignored", 3, 1'b0);
  endtask

  task automatic t_wideSplit();
    regWrite(8'h08, 4);
    setCand(1, 8'h45);
    ackExpect("R7 ack split4", 1);
    candVec[1] = 1'b0;
    readExpect("R4 group split4", 8'h14, 8'h40);
    setCand(2, 8'h5F);
    ackExpect("R4 R5 same group", SPUR);
    prioArr[2] = 8'h30;
    ackExpect("R4 R5 lower group", 2);
    candVec[2] = 1'b0;
    readExpect("R4 group 0x20", 8'h14, 8'h20);
    eoiExpect("R8 split4 a", 2, 1'b1);
    eoiExpect("R8 split4 b", 1, 1'b1);
    regWrite(8'h08, 2);
  endtask

  task automatic t_disabled();
    regWrite(8'h00, 0);
    setCand(7, 8'h20);
    irqExpect("R6 disabled", 1'b0);
    ackExpect("R7 ack while disabled", 7);
    candVec[7] = 1'b0;
    eoiExpect("R8 disabled eoi", 7, 1'b1);
    regWrite(8'h00, 1);
  endtask

  task automatic t_full();
    setCand(4, 8'h80);
    ackExpect("R9 first", 4);
    candVec[4] = 1'b0;
    setCand(5, 8'h40);
    ackExpect("R9 second", 5);
    candVec[5] = 1'b0;
    setCand(6, 8'h10);
    irqExpect("R9 full irq", 1'b0);
    ackExpect("R9 full ack", SPUR);
    readExpect("R9 running kept", 8'h14, 8'h40);
    eoiExpect("R9 pop", 5, 1'b1);
    irqExpect("R9 room again", 1'b1);
    ackExpect("R9 take", 6);
    candVec[6] = 1'b0;
    eoiExpect("R9 pop6", 6, 1'b1);
    eoiExpect("R9 pop4", 4, 1'b1);
    readExpect("R9 idle", 8'h14, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < N; i++) prioArr[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_arbitrate();
    t_split();
    t_mask();
    t_nest();
    t_wideSplit();
    t_disabled();
    t_full();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #800000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule